// File: doc/BRIEF.md
# Three-Level Masking Interrupt Controller

This block collects interrupt requests from three kinds of source: one non-maskable line, a set of external request lines and a set of on-chip peripheral request lines. Each maskable source has its own enable bit and a one-bit priority level. The block combines those levels with two condition-code bits from the CPU, a global mask bit and a user mask bit. The result is three masking states: nothing masked, only low-level sources masked, and everything masked except the non-maskable line.

At each instruction-boundary strobe, the block picks one winner from the eligible requests. A pending non-maskable request always wins. Otherwise a high-level source beats a low-level one, and within one level the source with the lowest index wins. The block registers the winner's index as a vector. It also emits a one-cycle accept pulse and a one-cycle request for the CPU to raise its global mask bit.

A request that is not accepted is not latched inside the block. It is evaluated again in every cycle, for as long as its source holds the line. Saving the CPU context and fetching from the vector table are left to the CPU.

Top module: `intc_mask3`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vec_out`, `accept_pulse` and `set_i` are cleared to 0 after that edge.
- R2: An external or peripheral source whose enable bit is 0 is never accepted, even when its request line is high.
- R3: When no non-maskable request is eligible, an eligible level-1 source always wins over every eligible level-0 source.
- R4: Among eligible sources of the same level, the source with the lowest vector index wins.
- R5: With `i_bit` = 0, every enabled request is eligible, whatever its level and whatever `ui_bit` is.
- R6: With `i_bit` = 1 and `ui_bit` = 0, level-0 sources are masked and level-1 sources stay eligible.
- R7: With `i_bit` = 1 and `ui_bit` = 1, no external or peripheral source is accepted.
- R8: A high `nmi_req` is eligible under every mask state, and it wins over all other sources.
- R9: Acceptance happens only at a clock edge where `insn_done` = 1 and at least one source is eligible. In the cycle after such an edge, `accept_pulse` and `set_i` are both 1. In every other cycle both are 0.
- R10: `vec_out` keeps the index of the most recently accepted source, and it changes only in a cycle where `accept_pulse` is 1.
- R11: The vector index encoding is as follows. The non-maskable line has index 0. External line k has index 1+k. Peripheral line j has index 1+N_EXT+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| ext_req | input | N_EXT | External request lines |
| ext_en | input | N_EXT | Enable bit for each external line |
| ext_lvl | input | N_EXT | Priority level for each external line (1 = high) |
| per_req | input | N_PER | Peripheral request lines |
| per_en | input | N_PER | Enable bit for each peripheral line |
| per_lvl | input | N_PER | Priority level for each peripheral line (1 = high) |
| i_bit | input | 1 | CPU global mask bit |
| ui_bit | input | 1 | CPU user mask bit |
| insn_done | input | 1 | Instruction-boundary strobe |
| vec_out | output | VEC_W | Index of the last accepted source |
| accept_pulse | output | 1 | One-cycle pulse on acceptance |
| set_i | output | 1 | Request for the CPU to set its global mask bit |

## Verification
The directed patterns cover several distinctions:
- Every source requesting at once under each of the three mask states. This separates correct mask gating from inverted gating or a missing combination of the two mask bits.
- The mixed-level case with two high-level external lines. This shows whether level outranks index.
- Single disabled sources and ties among peripheral lines. These expose a dropped enable bit or a reversed tie-break.
- Strobe-low cycles. These show that nothing is accepted between instruction boundaries.

Random request, enable, level and mask patterns, taken with the strobe both high and low, then confirm the winner and the held vector against a bench model.

// File: rtl/intc_pkg.sv
// Package: shared constants for the three-level masking interrupt controller.
// Assumes: priority levels are one bit wide; index 0 is reserved for the
// non-maskable source.
package intc_pkg;

    // Encoding of a source's one-bit priority level.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int NMI_INDEX = 0;

    // Returns the number of vector bits needed for a given source count.
    function automatic int vec_bits(input int nsrc);
        return (nsrc <= 2) ? 1 : $clog2(nsrc);
    endfunction

endpackage

// File: rtl/intc_src_gate.sv
// Module: intc_src_gate
// Purpose: merges request and enable for every maskable source, then applies
// the mask state formed by the CPU bits i_bit and ui_bit to each source's
// level. It produces one eligibility vector for each level.
// Assumes: index 0 belongs to the non-maskable line, so bit 0 of both level
// vectors is always 0, and NMI is reported separately on nmi_elig.
module intc_src_gate
    import intc_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 4,
    localparam int NSRC = 1 + N_EXT + N_PER
) (
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_en,
    input  logic [N_PER-1:0] per_lvl,
    input  logic             i_bit,
    input  logic             ui_bit,
    output logic             nmi_elig,
    output logic [NSRC-1:0]  elig_hi,
    output logic [NSRC-1:0]  elig_lo
);

    logic [NSRC-1:0] raw_req;
    logic [NSRC-1:0] raw_en;
    logic [NSRC-1:0] raw_lvl;
    logic            hi_open;
    logic            lo_open;

    // Mask state: level 0 opens only when i_bit is clear; level 1 opens unless both bits are set.
    always_comb begin
        lo_open = ~i_bit;
        hi_open = ~(i_bit & ui_bit);
    end

    // The non-maskable line bypasses every mask.
    always_comb nmi_elig = nmi_req;

    assign raw_req[NMI_INDEX] = 1'b0;
    assign raw_en[NMI_INDEX]  = 1'b0;
    assign raw_lvl[NMI_INDEX] = LVL_LOW;

    genvar ge;
    generate
        for (ge = 0; ge < N_EXT; ge++) begin : g_ext
            assign raw_req[1+ge] = ext_req[ge];
            assign raw_en[1+ge]  = ext_en[ge];
            assign raw_lvl[1+ge] = ext_lvl[ge];
        end
    endgenerate

    genvar gp;
    generate
        for (gp = 0; gp < N_PER; gp++) begin : g_per
            assign raw_req[1+N_EXT+gp] = per_req[gp];
            assign raw_en[1+N_EXT+gp]  = per_en[gp];
            assign raw_lvl[1+N_EXT+gp] = per_lvl[gp];
        end
    endgenerate

    genvar gs;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_elig
            logic live;
            // A source is live only while its request and enable are both high.
            always_comb live = raw_req[gs] & raw_en[gs];
            // Send the live source to its level's vector when that level is open.
            always_comb begin
                elig_hi[gs] = live & (raw_lvl[gs] == LVL_HIGH) & hi_open;
                elig_lo[gs] = live & (raw_lvl[gs] == LVL_LOW)  & lo_open;
            end
        end
    endgenerate

endmodule

// File: rtl/intc_prio_pick.sv
// Module: intc_prio_pick
// Purpose: chooses one winner from the eligibility vectors. NMI comes first,
// then the lowest set index of the high level, then the lowest set index of
// the low level.
// Assumes: bit 0 of both level vectors is 0, and the vectors come straight
// from intc_src_gate.
module intc_prio_pick
    import intc_pkg::*;
#(
    parameter int NSRC  = 9,
    localparam int VEC_W = vec_bits(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_elig,
    input  logic [NSRC-1:0]  elig_hi,
    input  logic [NSRC-1:0]  elig_lo,
    output logic             grant_vld,
    output logic [VEC_W-1:0] grant_idx
);

    logic             hi_any;
    logic             lo_any;
    logic [VEC_W-1:0] hi_idx;
    logic [VEC_W-1:0] lo_idx;
    logic [NSRC-1:0]  elig_all;

    // Find the lowest set index in each level; the downward scan leaves the lowest one.
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (elig_hi[k]) hi_idx = VEC_W'(k);
            if (elig_lo[k]) lo_idx = VEC_W'(k);
        end
        hi_any = |elig_hi;
        lo_any = |elig_lo;
    end

    // Final selection order: NMI, then the high level, then the low level.
    always_comb begin
        grant_vld = nmi_elig | hi_any | lo_any;
        if (nmi_elig)    grant_idx = VEC_W'(NMI_INDEX);
        else if (hi_any) grant_idx = hi_idx;
        else             grant_idx = lo_idx;
    end

    // Union of both levels, used only by the checks below.
    always_comb elig_all = elig_hi | elig_lo;

    AST_GRANT_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !nmi_elig) |-> elig_all[grant_idx]); // R2
    AST_HIGH_BEATS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_elig && (elig_hi != '0)) |-> elig_hi[grant_idx]); // R3
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_elig |-> (grant_vld && grant_idx == VEC_W'(0))); // R8

endmodule

// File: rtl/intc_accept_reg.sv
// Module: intc_accept_reg
// Purpose: registers the chosen vector at an instruction boundary and raises
// a one-cycle accept pulse and a one-cycle request to set the mask bit.
// Assumes: synchronous active-low reset; grant inputs are combinational and
// valid in every cycle.
module intc_accept_reg #(
    parameter int VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             grant_vld,
    input  logic [VEC_W-1:0] grant_idx,
    output logic [VEC_W-1:0] vec_out,
    output logic             accept_pulse,
    output logic             set_i
);

    logic take;

    // Accept only at a boundary with a valid winner.
    always_comb take = insn_done & grant_vld;

    // Vector register: loads on acceptance, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_out <= '0;
        else if (take) vec_out <= grant_idx;
    end

    // Pulse registers: high for exactly the cycle after an acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_pulse <= 1'b0;
            set_i        <= 1'b0;
        end else begin
            accept_pulse <= take;
            set_i        <= take;
        end
    end

    AST_PULSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        accept_pulse |-> $past(insn_done)); // R9
    AST_SETI_TRACKS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> $past(grant_vld)); // R9
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_pulse |-> $stable(vec_out)); // R10

endmodule

// File: rtl/intc_mask3.sv
// Module: intc_mask3 (top)
// Purpose: a three-level masking interrupt controller. It joins source
// gating, priority selection and the acceptance register.
// Assumes: all inputs are synchronous to clk; the CPU sets its mask bit in
// response to set_i; source counts are set by N_EXT and N_PER.
module intc_mask3
    import intc_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 4,
    localparam int NSRC  = 1 + N_EXT + N_PER,
    localparam int VEC_W = vec_bits(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_en,
    input  logic [N_PER-1:0] per_lvl,
    input  logic             i_bit,
    input  logic             ui_bit,
    input  logic             insn_done,
    output logic [VEC_W-1:0] vec_out,
    output logic             accept_pulse,
    output logic             set_i
);

    logic             nmi_elig;
    logic [NSRC-1:0]  elig_hi;
    logic [NSRC-1:0]  elig_lo;
    logic             grant_vld;
    logic [VEC_W-1:0] grant_idx;

    intc_src_gate #(.N_EXT(N_EXT), .N_PER(N_PER)) u_gate (
        .nmi_req  (nmi_req),
        .ext_req  (ext_req),
        .ext_en   (ext_en),
        .ext_lvl  (ext_lvl),
        .per_req  (per_req),
        .per_en   (per_en),
        .per_lvl  (per_lvl),
        .i_bit    (i_bit),
        .ui_bit   (ui_bit),
        .nmi_elig (nmi_elig),
        .elig_hi  (elig_hi),
        .elig_lo  (elig_lo)
    );

    intc_prio_pick #(.NSRC(NSRC)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_elig  (nmi_elig),
        .elig_hi   (elig_hi),
        .elig_lo   (elig_lo),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    intc_accept_reg #(.VEC_W(VEC_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .insn_done    (insn_done),
        .grant_vld    (grant_vld),
        .grant_idx    (grant_idx),
        .vec_out      (vec_out),
        .accept_pulse (accept_pulse),
        .set_i        (set_i)
    );

    AST_NMI_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && insn_done) |=> (accept_pulse && vec_out == VEC_W'(0))); // R8
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (i_bit && ui_bit && !nmi_req) |=> !accept_pulse); // R7
    AST_NO_STROBE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> (!accept_pulse && !set_i)); // R9

endmodule

// File: tb/intc_mask3_tb.sv
module intc_mask3_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_EXT = 4;
    localparam int N_PER = 4;
    localparam int NSRC  = 1 + N_EXT + N_PER;
    localparam int VEC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             nmi_req = 1'b0;
    logic [N_EXT-1:0] ext_req = '0, ext_en = '0, ext_lvl = '0;
    logic [N_PER-1:0] per_req = '0, per_en = '0, per_lvl = '0;
    logic             i_bit = 1'b0, ui_bit = 1'b0, insn_done = 1'b0;
    logic [VEC_W-1:0] vec_out;
    logic             accept_pulse, set_i;

    int n_checks = 0;
    int n_fail = 0;
    int hold_vec = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_mask3 #(.N_EXT(N_EXT), .N_PER(N_PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req),
        .ext_req(ext_req), .ext_en(ext_en), .ext_lvl(ext_lvl),
        .per_req(per_req), .per_en(per_en), .per_lvl(per_lvl),
        .i_bit(i_bit), .ui_bit(ui_bit), .insn_done(insn_done),
        .vec_out(vec_out), .accept_pulse(accept_pulse), .set_i(set_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference winner from the requirements (R3..R8, R11); -1 when none.
    function automatic int model_win();
        bit lo_open = !i_bit;
        bit hi_open = !(i_bit && ui_bit);
        if (nmi_req) return 0;
        for (int lv = 1; lv >= 0; lv--) begin
            for (int k = 0; k < N_EXT; k++)
                if (ext_req[k] && ext_en[k] && ext_lvl[k] == lv[0] &&
                    (lv == 1 ? hi_open : lo_open)) return 1 + k;
            for (int j = 0; j < N_PER; j++)
                if (per_req[j] && per_en[j] && per_lvl[j] == lv[0] &&
                    (lv == 1 ? hi_open : lo_open)) return 1 + N_EXT + j;
        end
        return -1;
    endfunction

    // One clock with the current inputs, then a check of all outputs.
    task automatic step(input string tag);
        int w = model_win();
        bit take = insn_done && (w >= 0);
        @(posedge clk);
        #1;
        if (take) hold_vec = w;
        chk({tag, " pulse"}, int'(accept_pulse), int'(take));
        chk({tag, " set_i"}, int'(set_i), int'(take));
        chk({tag, " vector"}, int'(vec_out), hold_vec);
    endtask

    task automatic clear_in();
        nmi_req = 0; ext_req = '0; ext_en = '0; ext_lvl = '0;
        per_req = '0; per_en = '0; per_lvl = '0;
        i_bit = 0; ui_bit = 0; insn_done = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clear_in();
        nmi_req = 1; insn_done = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset vector", int'(vec_out), 0);
        chk("R1 reset pulse", int'(accept_pulse), 0);
        chk("R1 reset set_i", int'(set_i), 0);
        clear_in();
        rst_n = 1;

        // R5: all sources, I=0 -> peripheral high level wins over lower index low level
        ext_req = '1; ext_en = '1; per_req = '1; per_en = '1; per_lvl = 4'b0100;
        insn_done = 1; ui_bit = 1;
        step("R5 I=0 all eligible, R3 level beats index");
        ext_lvl = '0; per_lvl = '0; ui_bit = 0;
        step("R4 R11 tie lowest index IRQ0");
        // Mixed level example: IRQ2, IRQ3 high
        ext_lvl = 4'b1100; i_bit = 1; ui_bit = 0;
        step("R6 I=1 UI=0 high level IRQ2 wins");
        ext_req[2] = 0;
        step("R6 IRQ3 next");
        ext_req[3] = 0;
        step("R6 level 0 masked");
        ext_req = '1; ui_bit = 1;
        step("R7 full mask");
        nmi_req = 1;
        step("R8 NMI under full mask");
        i_bit = 0; ui_bit = 0;
        step("R8 NMI beats all");
        nmi_req = 0; insn_done = 0;
        step("R9 no strobe no accept");
        step("R10 vector held");
        // R2: disabled sources
        clear_in(); insn_done = 1;
        ext_req = 4'b0011; ext_en = 4'b0010; per_req = 4'b1000; per_en = 4'b0000;
        step("R2 disabled IRQ0 skipped");
        ext_en = '0;
        step("R2 all disabled no accept");
        // R4 peripheral tie
        per_req = 4'b1010; per_en = '1;
        step("R4 R11 peripheral tie");

        // Random
        for (int n = 0; n < 400; n++) begin
            nmi_req   = ($urandom_range(0, 9) == 0);
            ext_req   = 4'($urandom); ext_en = 4'($urandom); ext_lvl = 4'($urandom);
            per_req   = 4'($urandom); per_en = 4'($urandom); per_lvl = 4'($urandom);
            i_bit     = 1'($urandom); ui_bit = 1'($urandom);
            insn_done = 1'($urandom);
            step("R3 R4 R5 R6 R7 random");
        end

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial void'($urandom(32'd1234));
endmodule